// File: doc/BRIEF.md
# Tower-Field GF(4096) Multiplier

This block multiplies two 12-bit elements of GF(2^12). The field is built as a quadratic extension over the 6-bit subfield GF(64), so one wide multiply becomes a few narrow ones. Each operand is split into an upper and a lower 6-bit half. Three subfield products are formed, plus one product with a fixed subfield constant, and XOR networks merge them into the 12-bit result. An encoder or syndrome-based decoder uses it wherever a symbol product is needed. Such a decoder handles 8 syndromes of 12 bits each, and a 32-bit register word carries two of them, in bits 11:0 and 27:16.

A second mode advances a Reed-Solomon generator sequence by one position. In this mode the second operand is replaced by the fixed element 0xE01, and an input of zero maps to one. The datapath is purely combinational. A parameter adds one output register stage, which is the default.

Top module: `gfTowerMul`

## Requirements
- R1: The subfield GF(64) is defined by x^6 + x + 1. Shift-and-add multiplication reduces with 0x43 whenever bit 6 is set. Each operand splits into a high half in bits 11:6 and a low half in bits 5:0, and the product is the concatenation {high, low}.
- R2: The high result half is (ah XOR al)·(bh XOR bl) XOR al·bl, computed in GF(64).
- R3: The low result half is (ah·bh)·0x21 XOR al·bl. The constant 0x21 is the inverse of the subfield generator 0x02, which follows from the extension polynomial X^2 + X + A^-1.
- R4: If either operand is zero in multiply mode, the product is zero.
- R5: The element 0x001 is the multiplicative identity: multiplying any element by it returns that element.
- R6: Multiplication is commutative: swapping opA and opB gives the same product.
- R7: When stepMode is 1, the product is opA·0xE01 and opB has no effect.
- R8: When stepMode is 1 and opA is zero, the product is 0x001.
- R9: With REGISTER_OUT = 1, product and outValid update on the clock edge that samples inValid = 1. Reset clears product to 0 and outValid to 0.
- R10: With REGISTER_OUT = 1, a cycle with inValid = 0 keeps product unchanged and drives outValid to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operands and mode are valid this cycle |
| stepMode | input | 1 | 1: generator step (opA times 0xE01, zero maps to one); 0: multiply opA by opB |
| opA | input | 12 | First operand |
| opB | input | 12 | Second operand, ignored in step mode |
| product | output | 12 | Field product |
| outValid | output | 1 | product holds a new result |

## Verification
The hardest situation to reach from the ports is one where the high halves, the low halves, and their XOR sums are all nonzero at once, so that the folded 0x21 term and both cross terms act on the result together. Directed all-ones and single-half operands alone leave one of these paths at zero. Seeded random operand pairs therefore fill most of the run. Each result is compared with a bench model that multiplies the halves as polynomials, reduces by long division, and obtains the folding constant by searching for the inverse of the generator. The step mode is driven with the same opA and two different opB values to show that opB is ignored. The zero-to-one case is driven directly.

// File: rtl/gfTowerPkg.sv
package gfTowerPkg;
  localparam int FULL_W = 12;
  localparam int SUB_W = FULL_W / 2;
  localparam logic [SUB_W:0] SUB_POLY = 7'h43;
  localparam logic [SUB_W-1:0] EXT_CONST = 6'h21;
  localparam logic [FULL_W-1:0] STEP_CONST = 12'hE01;

  typedef struct packed {
    logic capture;
    logic useStep;
    logic forceOne;
  } mulStrobe_t;
endpackage

// File: rtl/gfSubMul.sv
module gfSubMul #(
  parameter int W = gfTowerPkg::SUB_W,
  parameter logic [W:0] POLY = gfTowerPkg::SUB_POLY
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] z
);
  logic [W:0] shifted;
  logic [W-1:0] acc;

  always_comb begin
    acc = '0;
    shifted = {1'b0, y};
    for (int i = 0; i < W; i++) begin
      if (x[i]) acc = acc ^ shifted[W-1:0];
      shifted = {shifted[W-1:0], 1'b0};
      if (shifted[W]) shifted = shifted ^ POLY;
    end
    z = acc;
  end
endmodule

// File: rtl/gfMulCtrl.sv
module gfMulCtrl #(
  parameter int W = gfTowerPkg::FULL_W
) (
  input  logic inValid,
  input  logic stepMode,
  input  logic [W-1:0] opA,
  output gfTowerPkg::mulStrobe_t strobe
);
  always_comb begin
    strobe.capture = inValid;
    strobe.useStep = stepMode;
    strobe.forceOne = stepMode && (opA == '0);
  end
endmodule

// File: rtl/gfMulPath.sv
module gfMulPath #(
  parameter int W = gfTowerPkg::FULL_W,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  gfTowerPkg::mulStrobe_t strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] product,
  output logic outValid
);
  import gfTowerPkg::*;
  localparam int H = W / 2;

  logic [W-1:0] effB;
  logic [H-1:0] aHi, aLo, bHi, bLo;
  logic [H-1:0] crossProd, lowProd, highProd, foldedProd;
  logic [W-1:0] towerProd, combOut;

  assign effB = strobe.useStep ? STEP_CONST : opB;
  assign aHi = opA[W-1:H];
  assign aLo = opA[H-1:0];
  assign bHi = effB[W-1:H];
  assign bLo = effB[H-1:0];

  gfSubMul #(.W(H)) uCross (.x(aHi ^ aLo), .y(bHi ^ bLo), .z(crossProd));
  gfSubMul #(.W(H)) uLow   (.x(aLo),       .y(bLo),       .z(lowProd));
  gfSubMul #(.W(H)) uHigh  (.x(aHi),       .y(bHi),       .z(highProd));
  gfSubMul #(.W(H)) uFold  (.x(highProd),  .y(EXT_CONST), .z(foldedProd));

  assign towerProd = {crossProd ^ lowProd, foldedProd ^ lowProd};
  assign combOut = strobe.forceOne ? W'(1) : towerProd;

  // R4
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.useStep && (opA == '0 || opB == '0)) |-> (towerProd == '0));

  // R5
  identity_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.useStep && opB == W'(1)) |-> (towerProd == opA));

  generate
    if (REGISTER_OUT) begin : gRegOut
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          product <= '0;
          outValid <= 1'b0;
        end else begin
          outValid <= strobe.capture;
          if (strobe.capture) product <= combOut;
        end
      end

      // R9
      capture_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capture |=> (product == $past(combOut) && outValid));

      // R10
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.capture |=> ($stable(product) && !outValid));

      // R8
      step_zero_one_chk: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capture && strobe.useStep && opA == '0) |=> (product == W'(1)));
    end else begin : gCombOut
      assign product = combOut;
      assign outValid = strobe.capture;
    end
  endgenerate
endmodule

// File: rtl/gfTowerMul.sv
module gfTowerMul #(
  parameter int DATA_W = gfTowerPkg::FULL_W,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic stepMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] product,
  output logic outValid
);
  gfTowerPkg::mulStrobe_t strobe;

  gfMulCtrl #(.W(DATA_W)) uCtrl (
    .inValid(inValid), .stepMode(stepMode), .opA(opA), .strobe(strobe)
  );

  gfMulPath #(.W(DATA_W), .REGISTER_OUT(REGISTER_OUT)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .product(product), .outValid(outValid)
  );
endmodule

// File: tb/test_gfTowerMul.sv
module test_gfTowerMul;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic stepMode = 1'b0;
  logic [11:0] opA = '0;
  logic [11:0] opB = '0;
  logic [11:0] product;
  logic outValid;
  int errors = 0;
  int checks = 0;
  logic [5:0] foldC;

  always #2 clk = ~clk;

  gfTowerMul i_gfTowerMul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stepMode(stepMode),
    .opA(opA), .opB(opB), .product(product), .outValid(outValid)
  );

  function automatic logic [5:0] refSub(input logic [5:0] a, input logic [5:0] b);
    logic [10:0] p = '0;
    for (int i = 0; i < 6; i++) if (b[i]) p = p ^ (11'(a) << i);
    for (int i = 10; i >= 6; i--) if (p[i]) p = p ^ (11'h043 << (i - 6));
    return p[5:0];
  endfunction

  function automatic logic [11:0] refMul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] ah = a[11:6], al = a[5:0], bh = b[11:6], bl = b[5:0];
    logic [5:0] hh = refSub(ah, bh);
    logic [5:0] hi = hh ^ refSub(ah, bl) ^ refSub(al, bh);
    logic [5:0] lo = refSub(hh, foldC) ^ refSub(al, bl);
    return {hi, lo};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] a, input logic [11:0] b, input logic step,
                       output logic [11:0] res);
    @(negedge clk);
    opA = a; opB = b; stepMode = step; inValid = 1'b1;
    @(posedge clk);
    #1;
    res = product;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [11:0] r1, r2;
    void'($urandom(32'd4242));
    foldC = '0;
    for (int k = 1; k < 64; k++) if (refSub(6'h02, 6'(k)) == 6'h01) foldC = 6'(k);
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset product", product, 12'h000);
    check("R9 reset outValid", {11'b0, outValid}, 12'h000);
    @(negedge clk) rstN = 1'b1;

    // R1 R2 R3: directed corner operands
    apply(12'hFFF, 12'hFFF, 1'b0, r1); check("R1 all-ones", r1, refMul(12'hFFF, 12'hFFF));
    apply(12'h040, 12'h040, 1'b0, r1); check("R3 high-only fold", r1, refMul(12'h040, 12'h040));
    apply(12'h03F, 12'hFC0, 1'b0, r1); check("R2 cross halves", r1, refMul(12'h03F, 12'hFC0));
    apply(12'h002, 12'h020, 1'b0, r1); check("R1 subfield reduce", r1, 12'h003);
    check("R9 outValid after capture", {11'b0, outValid}, 12'h001);

    // R10: idle cycle keeps product
    @(negedge clk); opA = 12'h123; opB = 12'h456; inValid = 1'b0;
    @(posedge clk); #1;
    check("R10 hold product", product, 12'h003);
    check("R10 outValid low", {11'b0, outValid}, 12'h000);

    // R4 R5
    apply(12'hABC, 12'h000, 1'b0, r1); check("R4 zero opB", r1, 12'h000);
    apply(12'h000, 12'h5A5, 1'b0, r1); check("R4 zero opA", r1, 12'h000);
    apply(12'h9D3, 12'h001, 1'b0, r1); check("R5 identity opB", r1, 12'h9D3);
    apply(12'h001, 12'h7E4, 1'b0, r1); check("R5 identity opA", r1, 12'h7E4);

    // R8 R7
    apply(12'h000, 12'h3C3, 1'b1, r1); check("R8 step zero", r1, 12'h001);
    apply(12'h001, 12'h000, 1'b1, r1); check("R7 step one", r1, 12'hE01);

    for (int n = 0; n < 300; n++) begin
      logic [11:0] a = 12'($urandom), b = 12'($urandom);
      apply(a, b, 1'b0, r1); check("R1 R2 R3 random product", r1, refMul(a, b));
      apply(b, a, 1'b0, r2); check("R6 commutative", r2, r1);
      apply(a, b, 1'b1, r1);
      check("R7 step", r1, (a == 12'h000) ? 12'h001 : refMul(a, 12'hE01));
      apply(a, ~b, 1'b1, r2); check("R7 opB ignored", r2, r1);
      apply(a, 12'h001, 1'b0, r1); check("R5 random identity", r1, a);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule